// File: doc/BRIEF.md
# SDR SDRAM Bring-Up and Refresh Sequencer

This block sits at the front of an SDR SDRAM controller. After reset it drives NOP and does nothing else. A pulse on `start` begins the power-up sequence. The block first holds NOP for a power-up wait of 200 µs, counted from the system clock frequency parameter. It then issues a precharge of all banks and a first mode-register load. Eight auto-refresh commands follow, and a second mode-register load, with no precharge before it, closes the sequence. Some devices only accept the mode word after they have been refreshed, which is why the mode is loaded twice. Every command is followed by a configurable run of NOP cycles that covers tRP, tMRD or tRFC.

Once the second mode load is out, `init_done` rises and a free-running refresh timer starts. The timer counts a number of prescaler ticks set for a 31.2 µs interval. At 50 MHz this is 195 ticks of a divide-by-8 prescaler. Each time the timer expires, the block issues a burst of four auto-refreshes, which gives 8192 refreshes every 64 ms. After memory sizing, the surrounding logic may raise `slow_refresh` for parts of 32 MB or less. That switches the prescaler to divide-by-16 and halves the refresh rate.

The sequence is walked by a state machine:
- `ST_IDLE`: waits for `start`, then goes to `ST_POWERUP`.
- `ST_POWERUP`: when the wait counter reaches zero, goes to `ST_PRECHARGE`.
- Each command state goes to `ST_GAP`, which returns to a stored next state once the NOP count is spent:
  - `ST_PRECHARGE` returns to `ST_MODE_A`.
  - `ST_MODE_A` returns to `ST_REFRESH`.
  - `ST_REFRESH` repeats until its count is reached. It then returns to `ST_MODE_B` during bring-up, or to `ST_READY` afterwards.
  - `ST_MODE_B` returns to `ST_READY`.
- `ST_READY`: on a pending refresh request, goes to `ST_REFRESH`.

Top module: `sdr_bringup_seq`

## Requirements
- R1: While reset is asserted, `sdr_cmd` is NOP (2'd0), `sdr_addr` is zero and `init_done` is low.
- R2: Until `start` has been seen, the command output stays NOP and `init_done` stays low.
- R3: After `start`, at least WAIT_CYC = (CLK_HZ/1e6)*200 cycles of NOP pass before the first other command. The first command comes no later than WAIT_CYC+2 cycles after the start cycle.
- R4: The bring-up command order is PRECHARGE-ALL (2'd1), MODE-SET (2'd3), eight AUTO-REFRESH (2'd2), MODE-SET (2'd3).
- R5: Every MODE-SET carries the mode word 0x22 on `sdr_addr`, with all other bits zero: CAS latency 2, sequential burst of 4, burst writes. PRECHARGE-ALL drives `sdr_addr[10]` high.
- R6: Each command is followed by exactly TRP_NOPS, TMRD_NOPS or TRFC_NOPS NOP cycles, according to its kind, and two non-NOP commands are never adjacent.
- R7: `init_done` rises in the cycle after the second MODE-SET and stays high until reset.
- R8: Once `init_done` is high, refresh arrives in bursts of four AUTO-REFRESH commands spaced TRFC_NOPS+1 cycles apart. Bursts start exactly REF_TICKS*8 cycles apart.
- R9: With `slow_refresh` high, burst starts are REF_TICKS*16 cycles apart.
- R10: After `init_done`, only NOP and AUTO-REFRESH appear, and `start` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins the power-up sequence |
| slow_refresh | input | 1 | High selects the halved refresh rate (divide-by-16 prescaler) |
| sdr_cmd | output | 2 | Command: 0 NOP, 1 PRECHARGE-ALL, 2 AUTO-REFRESH, 3 MODE-SET |
| sdr_addr | output | ADDR_W | Address bus: mode word on MODE-SET, bit 10 on PRECHARGE-ALL |
| init_done | output | 1 | High once periodic refresh is running |

## Verification
The hardest behaviour to reach from the ports is the rate change. The prescaler switches divisor mid-count, so the first interval after `slow_refresh` rises has an arbitrary length. Only the intervals that start after the switch show the halved rate. The bench runs the sequencer at a reduced clock parameter to keep the power-up wait and the refresh interval short. It logs every non-NOP command with its cycle stamp, groups the auto-refreshes into bursts by their spacing, and checks only the burst-to-burst spacings that lie wholly on one side of the switch. A `start` pulse is also issued while refresh is running, to show that it cannot restart the bring-up.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP       = 2'd0,
        CMD_PRECHARGE = 2'd1,
        CMD_REFRESH   = 2'd2,
        CMD_MODE      = 2'd3
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POWERUP,
        ST_PRECHARGE,
        ST_MODE_A,
        ST_REFRESH,
        ST_MODE_B,
        ST_GAP,
        ST_READY
    } seq_state_e;

    localparam int A10_BIT = 10;

endpackage

// File: rtl/sdr_gap_counter.sv
module sdr_gap_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int REF_TICKS = 195,
    parameter int FAST_DIV  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic slow,
    input  logic ack,
    output logic req
);

    localparam int PRE_W  = $clog2(2 * FAST_DIV);
    localparam int TICK_W = $clog2(REF_TICKS + 1);
    localparam logic [PRE_W-1:0]  FAST_LIM  = PRE_W'(FAST_DIV - 1);
    localparam logic [PRE_W-1:0]  SLOW_LIM  = PRE_W'(2 * FAST_DIV - 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(REF_TICKS - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [TICK_W-1:0] tick_q;
    logic              pend_q;
    logic [PRE_W-1:0]  pre_lim;
    logic              pre_wrap;
    logic              expire;

    assign pre_lim  = slow ? SLOW_LIM : FAST_LIM;
    assign pre_wrap = (pre_q >= pre_lim);
    assign expire   = pre_wrap && (tick_q == TICK_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tick_q <= '0;
            pend_q <= 1'b0;
        end else if (!en) begin
            pre_q  <= '0;
            tick_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (pre_wrap) begin
                pre_q  <= '0;
                tick_q <= (tick_q == TICK_LAST) ? '0 : tick_q + TICK_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
            if (expire) begin
                pend_q <= 1'b1;
            end else if (ack) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign req = pend_q;

endmodule

// File: rtl/sdr_seq_fsm.sv
module sdr_seq_fsm
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int CNT_W      = 14,
    parameter int WAIT_CYC   = 10000,
    parameter int TRP_NOPS   = 2,
    parameter int TRFC_NOPS  = 7,
    parameter int TMRD_NOPS  = 2,
    parameter int INIT_REFS  = 8,
    parameter int BURST_REFS = 4,
    parameter int MODE_WORD  = 'h22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              gap_zero,
    input  logic              ref_req,
    output logic              gap_load,
    output logic [CNT_W-1:0]  gap_val,
    output logic              ref_ack,
    output logic [1:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int RC_W = $clog2(INIT_REFS + 1);
    localparam logic [RC_W-1:0] INIT_TGT  = RC_W'(INIT_REFS);
    localparam logic [RC_W-1:0] BURST_TGT = RC_W'(BURST_REFS);

    seq_state_e      state_q, state_d;
    seq_state_e      ret_q, ret_d;
    logic [RC_W-1:0] refs_q, refs_d, refs_nx, refs_tgt;
    logic            done_q, done_d;

    assign refs_nx  = refs_q + RC_W'(1);
    assign refs_tgt = done_q ? BURST_TGT : INIT_TGT;

    // next-state logic
    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        refs_d  = refs_q;
        done_d  = done_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_POWERUP;
            ST_POWERUP:   if (gap_zero) state_d = ST_PRECHARGE;
            ST_PRECHARGE: begin
                state_d = ST_GAP;
                ret_d   = ST_MODE_A;
            end
            ST_MODE_A: begin
                state_d = ST_GAP;
                ret_d   = ST_REFRESH;
                refs_d  = '0;
            end
            ST_REFRESH: begin
                state_d = ST_GAP;
                refs_d  = refs_nx;
                if (refs_nx == refs_tgt) begin
                    ret_d = done_q ? ST_READY : ST_MODE_B;
                end else begin
                    ret_d = ST_REFRESH;
                end
            end
            ST_MODE_B: begin
                state_d = ST_GAP;
                ret_d   = ST_READY;
                done_d  = 1'b1;
            end
            ST_GAP:       if (gap_zero) state_d = ret_q;
            ST_READY: begin
                if (ref_req) begin
                    state_d = ST_REFRESH;
                    refs_d  = '0;
                end
            end
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
            refs_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            refs_q  <= refs_d;
            done_q  <= done_d;
        end
    end

    // outputs
    always_comb begin
        cmd      = CMD_NOP;
        addr     = '0;
        gap_load = 1'b0;
        gap_val  = '0;
        ref_ack  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                gap_load = start;
                gap_val  = CNT_W'(WAIT_CYC - 1);
            end
            ST_PRECHARGE: begin
                cmd           = CMD_PRECHARGE;
                addr[A10_BIT] = 1'b1;
                gap_load      = 1'b1;
                gap_val       = CNT_W'(TRP_NOPS - 1);
            end
            ST_MODE_A, ST_MODE_B: begin
                cmd      = CMD_MODE;
                addr     = ADDR_W'(MODE_WORD);
                gap_load = 1'b1;
                gap_val  = CNT_W'(TMRD_NOPS - 1);
            end
            ST_REFRESH: begin
                cmd      = CMD_REFRESH;
                gap_load = 1'b1;
                gap_val  = CNT_W'(TRFC_NOPS - 1);
            end
            ST_READY:   ref_ack = ref_req;
            ST_POWERUP, ST_GAP: begin
                cmd = CMD_NOP;
            end
            default:    cmd = CMD_NOP;
        endcase
    end

    assign init_done = done_q;

endmodule

// File: rtl/sdr_bringup_seq.sv
module sdr_bringup_seq #(
    parameter int CLK_HZ           = 50_000_000,
    parameter int POWERUP_US       = 200,
    parameter int REFRESH_TENTH_US = 312,
    parameter int FAST_DIV         = 8,
    parameter int TRP_NOPS         = 2,
    parameter int TRFC_NOPS        = 7,
    parameter int TMRD_NOPS        = 2,
    parameter int INIT_REFS        = 8,
    parameter int BURST_REFS       = 4,
    parameter int ADDR_W           = 13,
    parameter int MODE_WORD        = 'h22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              slow_refresh,
    output logic [1:0]        sdr_cmd,
    output logic [ADDR_W-1:0] sdr_addr,
    output logic              init_done
);

    localparam int WAIT_CYC  = (CLK_HZ / 1_000_000) * POWERUP_US;
    localparam int REF_TICKS = (CLK_HZ / 1000) * REFRESH_TENTH_US / (10_000 * FAST_DIV);
    localparam int CNT_W     = $clog2(WAIT_CYC + 1);

    logic             gap_load;
    logic [CNT_W-1:0] gap_val;
    logic             gap_zero;
    logic             ref_req;
    logic             ref_ack;

    sdr_gap_counter #(
        .CNT_W (CNT_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    sdr_refresh_timer #(
        .REF_TICKS (REF_TICKS),
        .FAST_DIV  (FAST_DIV)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .slow  (slow_refresh),
        .ack   (ref_ack),
        .req   (ref_req)
    );

    sdr_seq_fsm #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .WAIT_CYC   (WAIT_CYC),
        .TRP_NOPS   (TRP_NOPS),
        .TRFC_NOPS  (TRFC_NOPS),
        .TMRD_NOPS  (TMRD_NOPS),
        .INIT_REFS  (INIT_REFS),
        .BURST_REFS (BURST_REFS),
        .MODE_WORD  (MODE_WORD)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .gap_zero  (gap_zero),
        .ref_req   (ref_req),
        .gap_load  (gap_load),
        .gap_val   (gap_val),
        .ref_ack   (ref_ack),
        .cmd       (sdr_cmd),
        .addr      (sdr_addr),
        .init_done (init_done)
    );

endmodule

// File: rtl/sdr_bringup_chk.sv
module sdr_bringup_chk
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int MODE_WORD = 'h22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        sdr_cmd,
    input logic [ADDR_W-1:0] sdr_addr,
    input logic              init_done
);

    logic seen_start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_start_q <= 1'b0;
        else if (start) seen_start_q <= 1'b1;
    end

    // R1: reset state
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (sdr_cmd == CMD_NOP && !init_done);
        end
    end

    // R2
    p_quiet_before_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start_q |-> (sdr_cmd == CMD_NOP && !init_done));

    // R5
    p_mode_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cmd == CMD_MODE) |-> (sdr_addr == ADDR_W'(MODE_WORD)));

    p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cmd == CMD_PRECHARGE) |-> sdr_addr[A10_BIT]);

    // R6
    p_nop_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cmd != CMD_NOP) |=> (sdr_cmd == CMD_NOP));

    // R7
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_done_after_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ($past(sdr_cmd) == CMD_MODE));

    // R10
    p_only_refresh_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (sdr_cmd == CMD_NOP || sdr_cmd == CMD_REFRESH));

endmodule

bind sdr_bringup_seq sdr_bringup_chk #(
    .ADDR_W    (ADDR_W),
    .MODE_WORD (MODE_WORD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sdr_cmd   (sdr_cmd),
    .sdr_addr  (sdr_addr),
    .init_done (init_done)
);

// File: tb/sdr_bringup_seq_tb.sv
module sdr_bringup_seq_tb;

    localparam int CLK_HZ   = 10_000_000;
    localparam int TRP      = 2;
    localparam int TRFC     = 7;
    localparam int TMRD     = 2;
    localparam int ADDR_W   = 13;
    localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * 200;
    localparam int TICKS    = (CLK_HZ / 1000) * 312 / 80_000;
    localparam int FAST_IV  = TICKS * 8;
    localparam int SLOW_IV  = TICKS * 16;
    localparam int LOG_N    = 128;

    // expected bring-up vectors: command code and NOPs after it (R4, R6)
    localparam int N_INIT = 11;
    localparam logic [1:0] EXP_CMD [N_INIT] =
        '{2'd1, 2'd3, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd3};
    localparam int EXP_GAP [N_INIT] =
        '{TRP, TMRD, TRFC, TRFC, TRFC, TRFC, TRFC, TRFC, TRFC, TRFC, TMRD};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              slow_refresh = 1'b0;
    logic [1:0]        sdr_cmd;
    logic [ADDR_W-1:0] sdr_addr;
    logic              init_done;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    logic [1:0]        lg_cmd  [LOG_N];
    logic [ADDR_W-1:0] lg_addr [LOG_N];
    int                lg_cyc  [LOG_N];
    int                n_log = 0;
    bit                done_seen = 0;
    int                done_cyc = 0;

    always #4 clk = ~clk;

    sdr_bringup_seq #(
        .CLK_HZ    (CLK_HZ),
        .TRP_NOPS  (TRP),
        .TRFC_NOPS (TRFC),
        .TMRD_NOPS (TMRD),
        .ADDR_W    (ADDR_W)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .slow_refresh (slow_refresh),
        .sdr_cmd      (sdr_cmd),
        .sdr_addr     (sdr_addr),
        .init_done    (init_done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sdr_cmd != 2'd0 && n_log < LOG_N) begin
                lg_cmd[n_log]  = sdr_cmd;
                lg_addr[n_log] = sdr_addr;
                lg_cyc[n_log]  = cyc;
                n_log = n_log + 1;
            end
            if (init_done && !done_seen) begin
                done_seen = 1;
                done_cyc  = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int start_cyc;
        int sw_cyc;
        int gs [LOG_N];
        int n_gs;
        int gsz [LOG_N];

        // R1: reset state
        repeat (5) @(negedge clk);
        chk(sdr_cmd == 2'd0, "R1", "cmd in reset", int'(sdr_cmd), 0);
        chk(sdr_addr == '0, "R1", "addr in reset", int'(sdr_addr), 0);
        chk(init_done == 1'b0, "R1", "init_done in reset", int'(init_done), 0);
        rst_n = 1'b1;

        // R2: idle without start
        repeat (50) @(negedge clk);
        chk(n_log == 0, "R2", "commands before start", n_log, 0);
        chk(init_done == 1'b0, "R2", "init_done before start", int'(init_done), 0);

        // start bring-up
        start_cyc = cyc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done_seen) @(negedge clk);

        // run fast refresh, with a stray start in the middle (R10)
        repeat (2 * FAST_IV) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3 * FAST_IV) @(negedge clk);

        // switch to slow refresh (R9)
        sw_cyc = cyc;
        slow_refresh = 1'b1;
        repeat (4 * SLOW_IV + 50) @(negedge clk);

        // R3: power-up wait
        chk(lg_cyc[0] - start_cyc >= WAIT_CYC && lg_cyc[0] - start_cyc <= WAIT_CYC + 2,
            "R3", "power-up wait", lg_cyc[0] - start_cyc, WAIT_CYC + 1);

        // R4, R6: table walk over bring-up sequence
        for (int i = 0; i < N_INIT; i++) begin
            chk(lg_cmd[i] == EXP_CMD[i], "R4", $sformatf("command %0d", i),
                int'(lg_cmd[i]), int'(EXP_CMD[i]));
            if (i < N_INIT - 1) begin
                chk(lg_cyc[i+1] - lg_cyc[i] == EXP_GAP[i] + 1, "R6",
                    $sformatf("spacing after command %0d", i),
                    lg_cyc[i+1] - lg_cyc[i], EXP_GAP[i] + 1);
            end
        end

        // R5: address content
        chk(lg_addr[0][10] == 1'b1, "R5", "precharge A10", int'(lg_addr[0][10]), 1);
        chk(lg_addr[1] == 13'h22, "R5", "first mode word", int'(lg_addr[1]), 'h22);
        chk(lg_addr[10] == 13'h22, "R5", "second mode word", int'(lg_addr[10]), 'h22);

        // R7: init_done timing
        chk(done_cyc == lg_cyc[10] + 1, "R7", "init_done rise cycle", done_cyc, lg_cyc[10] + 1);
        chk(init_done == 1'b1, "R7", "init_done held", int'(init_done), 1);

        // R10: only refresh after bring-up
        for (int i = N_INIT; i < n_log; i++) begin
            chk(lg_cmd[i] == 2'd2, "R10", $sformatf("command %0d after init", i),
                int'(lg_cmd[i]), 2);
        end

        // group refreshes into bursts
        n_gs = 0;
        for (int i = N_INIT; i < n_log; i++) begin
            if (i == N_INIT || lg_cyc[i] - lg_cyc[i-1] > TRFC + 1) begin
                gs[n_gs]  = lg_cyc[i];
                gsz[n_gs] = 1;
                n_gs++;
            end else begin
                gsz[n_gs-1]++;
                chk(lg_cyc[i] - lg_cyc[i-1] == TRFC + 1, "R8", "in-burst spacing",
                    lg_cyc[i] - lg_cyc[i-1], TRFC + 1);
            end
        end
        chk(n_gs >= 8, "R8", "number of bursts", n_gs, 8);

        // R8: burst size and fast spacing
        for (int g = 0; g + 1 < n_gs; g++) begin
            chk(gsz[g] == 4, "R8", $sformatf("burst %0d size", g), gsz[g], 4);
            if (gs[g+1] < sw_cyc) begin
                chk(gs[g+1] - gs[g] == FAST_IV, "R8", "fast burst period",
                    gs[g+1] - gs[g], FAST_IV);
            end else if (gs[g] > sw_cyc) begin
                // R9: slow spacing
                chk(gs[g+1] - gs[g] == SLOW_IV, "R9", "slow burst period",
                    gs[g+1] - gs[g], SLOW_IV);
            end
        end

        finish_run();
    end

endmodule